// File: doc/BRIEF.md
# Per-Prediction Checkpoint Manager

During speculative execution each load whose value is predicted gets its own register checkpoint. This block keeps the bookkeeping for those checkpoints. An allocate request carries the predicted value. The block places it in a free slot and returns that slot's id, and the id names the checkpoint from then on. When the real load value arrives, a resolve port presents the id and the actual value. The block compares the actual value against the stored prediction.

When the two values are equal, the slot is simply freed and no restore takes place. When they differ, the block requests a rollback to that prediction's own checkpoint. In the same step it frees that slot and every slot allocated after it. Resolves may arrive in any order and on several ports in the same cycle. If more than one of them mispredicts, the one allocated earliest wins. The register file and the value predictor sit outside this block.

Top module: `ckpt_manager`

## Requirements
- R1: After reset no slot is occupied: `full` is 0, `allocId` is 0 and `rollbackValid` is 0.
- R2: In a cycle where `allocValid` is 1, `full` is 0 and no resolve port mispredicts, `allocAck` is 1 in that same cycle and `allocId` names the lowest-numbered free slot. That slot then holds `allocValue`.
- R3: `full` is 1 exactly when all 8 slots are occupied. While it is 1, `allocAck` stays 0 and no slot is taken.
- R4: A resolve whose value equals the stored prediction frees that slot. It causes no rollback: `rollbackValid` stays 0 in the next cycle.
- R5: A resolve on an occupied slot whose value differs from the stored prediction raises `rollbackValid` for one cycle, in the cycle after the resolve, with `rollbackId` equal to that slot.
- R6: A rollback frees its target slot and every slot allocated after the target. Slots allocated before the target stay occupied.
- R7: When several resolve ports mispredict in one cycle, `rollbackId` names the slot that was allocated earliest, whatever its index.
- R8: A resolve naming a free slot (for example, one freed by an earlier rollback) is ignored: it causes no rollback and does not change occupancy.
- R9: In a cycle in which any resolve port mispredicts, `allocAck` is 0 and no slot is taken.
- R10: Correct resolves may free slots in any order. A freed slot is reused by the next allocation whenever it is the lowest free index.
- R11: Resolve port p takes its id from bits [p*3 +: 3] of `resIdFlat` and its value from bits [p*VAL_W +: VAL_W] of `resValueFlat`, where VAL_W is 32 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Request for a new checkpoint |
| allocValue | input | VAL_W | Predicted value to store with the checkpoint |
| allocAck | output | 1 | Request accepted this cycle |
| allocId | output | 3 | Slot granted (lowest free index) |
| full | output | 1 | All slots occupied |
| resValid | input | RES_PORTS | Per-port resolve strobe |
| resIdFlat | input | RES_PORTS*3 | Per-port slot id being resolved |
| resValueFlat | input | RES_PORTS*VAL_W | Per-port actual load value |
| rollbackValid | output | 1 | Rollback request, one cycle |
| rollbackId | output | 3 | Checkpoint to restore |

## Verification
A wrong internal state shows up in two places at the ports. Occupancy errors show as a wrong `allocId` or `full` in the cycle right after the edge that caused them. Age-order errors stay hidden until a later misprediction or a resolve on a freed slot. At that point they appear as a wrong `rollbackId`, a missing rollback or a spurious one, one cycle after that resolve. The directed scenarios therefore always follow a kill or a release with a probe resolve, or with an allocation whose id exposes the surviving set.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  parameter int CkptNum = 8;
  localparam int CkptIdW = $clog2(CkptNum);

  typedef logic [CkptIdW-1:0] ckptId_t;

  typedef struct packed {
    logic                 allocEn;
    ckptId_t              allocIdx;
    logic [CkptNum-1:0]   releaseMask;
    logic [CkptNum-1:0]   killMask;
  } ckptStrobe_t;
endpackage

// File: rtl/ckpt_datapath.sv
module ckpt_datapath
  import ckpt_pkg::*;
#(
  parameter int VAL_W     = 32,
  parameter int RES_PORTS = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  ckptStrobe_t                          strobe,
  input  logic [VAL_W-1:0]                     allocValue,
  input  logic [RES_PORTS-1:0]                 resValid,
  input  ckptId_t [RES_PORTS-1:0]              resId,
  input  logic [RES_PORTS-1:0][VAL_W-1:0]      resValue,
  output logic [CkptNum-1:0]                   slotValid,
  output logic [CkptNum-1:0][CkptNum-1:0]      olderMat,
  output logic [RES_PORTS-1:0]                 mispredict,
  output logic [RES_PORTS-1:0]                 correct
);
  logic [CkptNum-1:0][VAL_W-1:0] slotValue;
  logic [CkptNum-1:0]            allocOneHot;

  assign allocOneHot = strobe.allocEn ? (CkptNum'(1) << strobe.allocIdx) : '0;

  // Per-port comparison against the stored prediction
  always_comb begin
    for (int p = 0; p < RES_PORTS; p++) begin
      mispredict[p] = resValid[p] && slotValid[resId[p]] &&
                      (slotValue[resId[p]] != resValue[p]);
      correct[p]    = resValid[p] && slotValid[resId[p]] &&
                      (slotValue[resId[p]] == resValue[p]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) slotValid <= '0;
    else slotValid <= (slotValid & ~strobe.releaseMask & ~strobe.killMask) | allocOneHot;
  end

  // One row per slot: row g bit k set means slot g is older than slot k
  for (genvar g = 0; g < CkptNum; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        olderMat[g]  <= '0;
        slotValue[g] <= '0;
      end else if (allocOneHot[g]) begin
        olderMat[g]  <= '0;
        slotValue[g] <= allocValue;
      end else begin
        olderMat[g]  <= olderMat[g] | allocOneHot;
      end
    end
  end
endmodule

// File: rtl/ckpt_control.sv
module ckpt_control
  import ckpt_pkg::*;
#(
  parameter int RES_PORTS = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            allocValid,
  input  logic [CkptNum-1:0]              slotValid,
  input  logic [CkptNum-1:0][CkptNum-1:0] olderMat,
  input  logic [RES_PORTS-1:0]            mispredict,
  input  logic [RES_PORTS-1:0]            correct,
  input  ckptId_t [RES_PORTS-1:0]         resId,
  output ckptStrobe_t                     strobe,
  output logic                            allocAck,
  output ckptId_t                         allocId,
  output logic                            full,
  output logic                            rollbackValid,
  output ckptId_t                         rollbackId
);
  logic                 anyMis;
  logic [RES_PORTS-1:0] isOldest;
  ckptId_t              targetId;
  ckptId_t              freeIdx;
  logic [CkptNum-1:0]   relMask;
  logic [CkptNum-1:0]   killMask;

  assign full   = &slotValid;
  assign anyMis = |mispredict;

  // Lowest free slot
  always_comb begin
    freeIdx = '0;
    for (int i = CkptNum - 1; i >= 0; i--)
      if (!slotValid[i]) freeIdx = CkptIdW'(i);
  end

  // Oldest mispredicting port; ties on the same id go to the lowest port
  always_comb begin
    for (int p = 0; p < RES_PORTS; p++) begin
      isOldest[p] = mispredict[p];
      for (int q = 0; q < RES_PORTS; q++)
        if (q != p && mispredict[q] && olderMat[resId[q]][resId[p]])
          isOldest[p] = 1'b0;
    end
    targetId = '0;
    for (int p = RES_PORTS - 1; p >= 0; p--)
      if (isOldest[p]) targetId = resId[p];
  end

  always_comb begin
    relMask = '0;
    for (int p = 0; p < RES_PORTS; p++)
      if (correct[p]) relMask[resId[p]] = 1'b1;
    killMask = anyMis ? ((olderMat[targetId] & slotValid) | (CkptNum'(1) << targetId)) : '0;
  end

  assign allocAck = allocValid && !full && !anyMis;
  assign allocId  = freeIdx;

  always_comb begin
    strobe.allocEn     = allocAck;
    strobe.allocIdx    = freeIdx;
    strobe.releaseMask = relMask;
    strobe.killMask    = killMask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rollbackValid <= 1'b0;
      rollbackId    <= '0;
    end else begin
      rollbackValid <= anyMis;
      if (anyMis) rollbackId <= targetId;
    end
  end
endmodule

// File: rtl/ckpt_manager.sv
module ckpt_manager
  import ckpt_pkg::*;
#(
  parameter int VAL_W     = 32,
  parameter int RES_PORTS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         allocValid,
  input  logic [VAL_W-1:0]             allocValue,
  output logic                         allocAck,
  output logic [CkptIdW-1:0]           allocId,
  output logic                         full,
  input  logic [RES_PORTS-1:0]         resValid,
  input  logic [RES_PORTS*CkptIdW-1:0] resIdFlat,
  input  logic [RES_PORTS*VAL_W-1:0]   resValueFlat,
  output logic                         rollbackValid,
  output logic [CkptIdW-1:0]           rollbackId
);
  ckptId_t [RES_PORTS-1:0]            resId;
  logic [RES_PORTS-1:0][VAL_W-1:0]    resValue;
  ckptStrobe_t                        strobe;
  logic [CkptNum-1:0]                 slotValid;
  logic [CkptNum-1:0][CkptNum-1:0]    olderMat;
  logic [RES_PORTS-1:0]               mispredict;
  logic [RES_PORTS-1:0]               correct;

  for (genvar p = 0; p < RES_PORTS; p++) begin : gUnpack
    assign resId[p]    = resIdFlat[p*CkptIdW +: CkptIdW];
    assign resValue[p] = resValueFlat[p*VAL_W +: VAL_W];
  end

  ckpt_datapath #(.VAL_W(VAL_W), .RES_PORTS(RES_PORTS)) uDp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .allocValue (allocValue),
    .resValid   (resValid),
    .resId      (resId),
    .resValue   (resValue),
    .slotValid  (slotValid),
    .olderMat   (olderMat),
    .mispredict (mispredict),
    .correct    (correct)
  );

  ckpt_control #(.RES_PORTS(RES_PORTS)) uCtl (
    .clk           (clk),
    .rst_n         (rst_n),
    .allocValid    (allocValid),
    .slotValid     (slotValid),
    .olderMat      (olderMat),
    .mispredict    (mispredict),
    .correct       (correct),
    .resId         (resId),
    .strobe        (strobe),
    .allocAck      (allocAck),
    .allocId       (allocId),
    .full          (full),
    .rollbackValid (rollbackValid),
    .rollbackId    (rollbackId)
  );
endmodule

// File: rtl/ckpt_manager_chk.sv
module ckpt_manager_chk
  import ckpt_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               allocAck,
  input logic [CkptIdW-1:0] allocId,
  input logic               full,
  input logic               rollbackValid,
  input logic [CkptIdW-1:0] rollbackId,
  input logic [CkptNum-1:0] slotValid
);
  // R2: a granted slot is free when granted
  p_grant_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    allocAck |-> !slotValid[allocId]);

  // R2: a granted slot is occupied after the edge
  p_grant_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    allocAck |=> slotValid[$past(allocId)]);

  // R3: no grant while full
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !allocAck);

  // R6: rollback target has been freed when the request appears
  p_target_freed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rollbackValid |-> !slotValid[rollbackId]);

  // R9: no grant in the cycle that caused a rollback
  p_no_grant_on_mis_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rollbackValid) |-> !$past(allocAck));
endmodule

bind ckpt_manager ckpt_manager_chk u_chk (.*);

// File: tb/sim_ckpt_manager.sv
`timescale 1ns/1ps
module sim_ckpt_manager;
  localparam int VW = 32;
  localparam int NP = 2;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic allocValid;
  logic [VW-1:0] allocValue;
  logic allocAck;
  logic [IW-1:0] allocId;
  logic full;
  logic [NP-1:0] resValid;
  logic [NP*IW-1:0] resIdFlat;
  logic [NP*VW-1:0] resValueFlat;
  logic rollbackValid;
  logic [IW-1:0] rollbackId;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ckpt_manager u0 (
    .clk(clk), .rst_n(rst_n),
    .allocValid(allocValid), .allocValue(allocValue),
    .allocAck(allocAck), .allocId(allocId), .full(full),
    .resValid(resValid), .resIdFlat(resIdFlat), .resValueFlat(resValueFlat),
    .rollbackValid(rollbackValid), .rollbackId(rollbackId)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    allocValid = 1'b0;
    allocValue = '0;
    resValid = '0;
    resIdFlat = '0;
    resValueFlat = '0;
  endtask

  task automatic doReset();
    idle();
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    #1;
  endtask

  task automatic allocOne(input int val, input int expId, input string req);
    allocValid = 1'b1;
    allocValue = VW'(val);
    #1;
    chk({req, " ack"}, int'(allocAck), 1);
    chk({req, " id"}, int'(allocId), expId);
    tick();
    allocValid = 1'b0;
  endtask

  task automatic setRes(input int port, input int id, input int val);
    resValid[port] = 1'b1;
    resIdFlat[port*IW +: IW] = IW'(id);
    resValueFlat[port*VW +: VW] = VW'(val);
  endtask

  task automatic resolveOne(input int id, input int val);
    setRes(0, id, val);
    tick();
    idle();
  endtask

  task automatic testReset();
    doReset();
    chk("R1 full", int'(full), 0);
    chk("R1 allocId", int'(allocId), 0);
    chk("R1 rollbackValid", int'(rollbackValid), 0);
  endtask

  task automatic testFillAndKill();
    doReset();
    for (int i = 0; i < 8; i++) allocOne(100 + i, i, "R2 fill");
    chk("R3 full set", int'(full), 1);
    allocValid = 1'b1; allocValue = 77;
    #1;
    chk("R3 no ack when full", int'(allocAck), 0);
    tick();
    idle();
    chk("R3 still full", int'(full), 1);
    resolveOne(5, 105);
    chk("R4 no rollback", int'(rollbackValid), 0);
    chk("R4 full cleared", int'(full), 0);
    chk("R4 slot 5 free", int'(allocId), 5);
    resolveOne(2, 102);
    chk("R10 out of order release", int'(allocId), 2);
    allocOne(200, 2, "R10 reuse");
    chk("R10 next free", int'(allocId), 5);
    resolveOne(3, 0);
    chk("R5 rollback valid", int'(rollbackValid), 1);
    chk("R5 rollback id", int'(rollbackId), 3);
    chk("R6 younger freed", int'(allocId), 2);
    resolveOne(4, 1);
    chk("R5 one-cycle pulse", int'(rollbackValid), 0);
    chk("R8 killed slot ignored", int'(allocId), 2);
    resolveOne(7, 9);
    chk("R8 no rollback on free slot", int'(rollbackValid), 0);
    resolveOne(1, 5);
    chk("R6 older kept", int'(rollbackValid), 1);
    chk("R6 older id", int'(rollbackId), 1);
    chk("R6 after second rollback", int'(allocId), 1);
    resolveOne(0, 100);
    chk("R4 last release", int'(rollbackValid), 0);
    chk("R4 all free", int'(allocId), 0);
  endtask

  task automatic testOldestWins();
    doReset();
    allocOne(10, 0, "R2 a");
    allocOne(11, 1, "R2 b");
    allocOne(12, 2, "R2 c");
    resolveOne(0, 10);
    chk("R4 release 0", int'(rollbackValid), 0);
    allocOne(20, 0, "R10 reuse 0");
    setRes(0, 0, 99);
    setRes(1, 2, 98);
    allocValid = 1'b1; allocValue = 5;
    #1;
    chk("R9 no ack on mispredict", int'(allocAck), 0);
    tick();
    idle();
    chk("R7 rollback valid", int'(rollbackValid), 1);
    chk("R7 oldest target", int'(rollbackId), 2);
    chk("R6 R9 free set", int'(allocId), 0);
    resolveOne(1, 11);
    chk("R4 R11 release on port 0", int'(rollbackValid), 0);
    chk("R4 empty", int'(allocId), 0);
  endtask

  task automatic testPortOne();
    doReset();
    allocOne(40, 0, "R11 a");
    allocOne(41, 1, "R11 b");
    setRes(1, 1, 7);
    tick();
    idle();
    chk("R11 port 1 rollback", int'(rollbackValid), 1);
    chk("R11 port 1 id", int'(rollbackId), 1);
    chk("R11 slot 0 kept", int'(allocId), 1);
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    testReset();
    testFillAndKill();
    testOldestWins();
    testPortOne();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule